// File: doc/BRIEF.md
# Synchronous Burst Block Read Sequencer

This block sits on the flash side of a memory subsystem and serves synchronous burst reads from a word-addressed array. A single-cycle start strobe captures a start address and a mode. The block then issues one read per clock to a synchronous RAM through its own incrementing address counter and forwards the returned words together with a valid flag. There are two modes. In continuous mode the counter rolls over inside the aligned block that holds the start address, and the stream runs until reset. In fixed-length mode the stream stops after a set number of words and raises a done indication.

The first word always arrives one cycle after the start is sampled, whatever the latency setting. A 3-bit wait-latency field sets the gap before the second word. After that gap, words arrive back to back. A one-cycle ready pulse marks the first word. An interrupt-style output and a status bit report that a fixed-length burst has completed. Pulling the write-enable input low during a burst is treated as illegal: the burst is aborted and a sticky error bit is set. The latency field and the status bits can be read at any time, including during a burst, by pairing an address-valid strobe with a register address.

Top module: `burst_read_seq`

## Requirements
- R1: When `start` is sampled high at edge 0 while idle, `dout_valid` is high after edge 1 and `dout` carries the word at the start address, for every latency setting.
- R2: The latency field is 3 bits wide and resets to 4. A `cfg_wr` of a value from 3 to 7 while idle replaces it. A value of 0, 1 or 2, or any write while a burst is active, leaves it unchanged.
- R3: With latency L, word k (k >= 1) is valid after edge L+k. `dout_valid` stays low after edges 2 to L.
- R4: `rdy` is high for exactly one cycle, the cycle that carries word 0, and is low otherwise.
- R5: Word k comes from an address whose bits above log2(BLOCK_WORDS) equal those of the start address and whose low bits are (start low bits + k) modulo BLOCK_WORDS.
- R6: A continuous burst delivers words for as long as it runs and stops only through `rst`. A `start` during a burst has no effect.
- R7: A fixed-length burst delivers FIXED_LEN words and then goes idle. `irq` and status bit 0 go high with the last word and stay high until the next accepted `start` clears them.
- R8: A continuous burst never sets `irq` or status bit 0.
- R9: `we_n` low in any cycle of a burst ends it. The read in that cycle is suppressed, no later word or `rdy` appears, `irq` is unchanged, and status bit 1 is set until `rst`.
- R10: `reg_avd` high with `reg_addr` 0 returns the latency in bits [2:0]. With `reg_addr` 1 it returns {error, done} in bits [1:0]. Unused bits are zero. The value appears on `reg_rdata` after the next edge and this works during a burst.
- R11: `rst` is synchronous and active high. It returns the block to idle with all outputs low, both status bits clear and the latency at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Burst start strobe |
| start_addr | input | AW | Word address of the first word |
| start_fixed | input | 1 | 1 selects fixed-length mode, 0 selects continuous mode |
| we_n | input | 1 | Write enable, active low; illegal during a burst |
| cfg_wr | input | 1 | Latency field write strobe |
| cfg_lat | input | 3 | Latency value to write |
| reg_avd | input | 1 | Register read address-valid strobe |
| reg_addr | input | 1 | Register select: 0 latency, 1 status |
| reg_rdata | output | 8 | Registered read data |
| mem_rd | output | 1 | Read request to the synchronous RAM |
| mem_addr | output | AW | RAM word address |
| mem_rdata | input | DW | RAM read data, one cycle after the request |
| dout | output | DW | Burst data word |
| dout_valid | output | 1 | `dout` carries a burst word |
| rdy | output | 1 | First-word ready pulse |
| irq | output | 1 | Fixed-length burst completed |

## Verification
A stuck or miscounted gap counter moves the second word off cycle L+1 and shows up as a `dout_valid` mismatch on the first cycle that differs. A counter that carries into the upper address bits, or fails to roll over, delivers a wrong `dout` on the first word past the block boundary, which the long continuous runs reach. A wrong remaining-word count shows up as an early or late `irq` and, on the cycles after the last word, as `dout_valid` that stays high or drops too soon. Sticky-bit and latency-register faults show in the next status or latency readback, which is taken during and after each burst.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FIRST,
        ST_GAP,
        ST_STREAM
    } seq_state_e;

    typedef struct packed {
        logic err;
        logic done;
    } seq_status_t;

    localparam logic [2:0] LAT_MIN   = 3'd3;
    localparam logic [2:0] LAT_RESET = 3'd4;
    localparam logic       SEL_LAT   = 1'b0;

    function automatic logic lat_legal(input logic [2:0] v);
        return v >= LAT_MIN;
    endfunction

    function automatic logic [7:0] pack_readback(input logic sel,
                                                 input logic [2:0] lat,
                                                 input seq_status_t st);
        if (sel == SEL_LAT)
            return {5'b0, lat};
        return {6'b0, st};
    endfunction

endpackage

// File: rtl/bsr_addr_gen.sv
module bsr_addr_gen #(
    parameter int AW = 16,
    parameter int OW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          step,
    output logic [AW-1:0] addr
);
    logic [AW-1:0] addr_q;
    logic [AW-1:0] addr_inc;

    generate
        if (OW >= AW) begin : g_whole
            assign addr_inc = addr_q + 1'b1;
        end else begin : g_block
            logic [OW-1:0] off_inc;
            assign off_inc  = addr_q[OW-1:0] + 1'b1;
            assign addr_inc = {addr_q[AW-1:OW], off_inc};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            addr_q <= '0;
        else if (load)
            addr_q <= load_addr;
        else if (step)
            addr_q <= addr_inc;
    end

    assign addr = addr_q;
endmodule

// File: rtl/bsr_ctrl.sv
module bsr_ctrl
    import burst_seq_pkg::*;
#(
    parameter int FIXED_LEN = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       start_fixed,
    input  logic       we_n,
    input  logic [2:0] lat,
    output logic       busy,
    output logic       load,
    output logic       step,
    output logic       mem_rd,
    output logic       fin,
    output logic       abort,
    output logic       dout_valid,
    output logic       rdy
);
    localparam int LW = $clog2(FIXED_LEN) + 1;

    seq_state_e    state_q;
    logic          fixed_q;
    logic [2:0]    gap_q;
    logic [LW-1:0] rem_q;
    logic          issuing;

    assign busy    = (state_q != ST_IDLE);
    assign abort   = busy && !we_n;
    assign issuing = (state_q == ST_FIRST) || (state_q == ST_STREAM);
    assign mem_rd  = issuing && we_n;
    assign load    = (state_q == ST_IDLE) && start;
    assign step    = mem_rd;
    assign fin     = (state_q == ST_STREAM) && fixed_q && (rem_q == LW'(1)) && we_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            fixed_q <= 1'b0;
            gap_q   <= '0;
            rem_q   <= '0;
        end else if (abort) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q <= ST_FIRST;
                    fixed_q <= start_fixed;
                    rem_q   <= LW'(FIXED_LEN - 1);
                end
                ST_FIRST: begin
                    state_q <= ST_GAP;
                    gap_q   <= lat - 3'd2;
                end
                ST_GAP: begin
                    if (gap_q == 3'd0)
                        state_q <= ST_STREAM;
                    else
                        gap_q <= gap_q - 3'd1;
                end
                ST_STREAM: begin
                    if (fin)
                        state_q <= ST_IDLE;
                    else
                        rem_q <= rem_q - LW'(1);
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_valid <= 1'b0;
            rdy        <= 1'b0;
        end else begin
            dout_valid <= mem_rd;
            rdy        <= mem_rd && (state_q == ST_FIRST);
        end
    end

    // R4: the ready pulse only ever accompanies a delivered word
    p_rdy_with_word_r4: assert property (@(posedge clk) disable iff (rst)
        rdy |-> dout_valid);

    // R9: an illegal write enable leaves the sequencer idle with no word
    p_abort_idle_r9: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !dout_valid));

    // R6: a continuous stream keeps issuing reads while write enable is high
    p_cont_runs_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STREAM && !fixed_q && we_n) |=> mem_rd || !we_n);
endmodule

// File: rtl/bsr_cfg_regs.sv
module bsr_cfg_regs
    import burst_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic [2:0] cfg_lat,
    input  logic       busy,
    input  logic       clr,
    input  logic       fin,
    input  logic       abort,
    input  logic       reg_avd,
    input  logic       reg_addr,
    output logic [2:0] lat,
    output logic       irq,
    output logic [7:0] reg_rdata
);
    logic [2:0]  lat_q;
    seq_status_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q     <= LAT_RESET;
            st_q      <= '0;
            reg_rdata <= '0;
        end else begin
            if (cfg_wr && !busy && lat_legal(cfg_lat))
                lat_q <= cfg_lat;
            if (clr)
                st_q.done <= 1'b0;
            else if (fin)
                st_q.done <= 1'b1;
            if (abort)
                st_q.err <= 1'b1;
            if (reg_avd)
                reg_rdata <= pack_readback(reg_addr, lat_q, st_q);
        end
    end

    assign lat = lat_q;
    assign irq = st_q.done;

    // R2: the latency field never leaves its legal range
    p_lat_range_r2: assert property (@(posedge clk) disable iff (rst)
        lat_q >= LAT_MIN);

    // R7: completion stays flagged until a new burst is accepted
    p_done_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (irq && !clr) |=> irq);

    // R9: the error bit is sticky
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        st_q.err |=> st_q.err);
endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int BLOCK_WORDS = 64,
    parameter int FIXED_LEN   = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic          start_fixed,
    input  logic          we_n,
    input  logic          cfg_wr,
    input  logic [2:0]    cfg_lat,
    input  logic          reg_avd,
    input  logic          reg_addr,
    output logic [7:0]    reg_rdata,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] dout,
    output logic          dout_valid,
    output logic          rdy,
    output logic          irq
);
    localparam int OW = $clog2(BLOCK_WORDS);

    logic       busy, load, step, fin, abort;
    logic [2:0] lat;

    bsr_ctrl #(.FIXED_LEN(FIXED_LEN)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_fixed(start_fixed),
        .we_n       (we_n),
        .lat        (lat),
        .busy       (busy),
        .load       (load),
        .step       (step),
        .mem_rd     (mem_rd),
        .fin        (fin),
        .abort      (abort),
        .dout_valid (dout_valid),
        .rdy        (rdy)
    );

    bsr_addr_gen #(.AW(AW), .OW(OW)) addr_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_addr(start_addr),
        .step     (step),
        .addr     (mem_addr)
    );

    bsr_cfg_regs regs_i (
        .clk      (clk),
        .rst      (rst),
        .cfg_wr   (cfg_wr),
        .cfg_lat  (cfg_lat),
        .busy     (busy),
        .clr      (load),
        .fin      (fin),
        .abort    (abort),
        .reg_avd  (reg_avd),
        .reg_addr (reg_addr),
        .lat      (lat),
        .irq      (irq),
        .reg_rdata(reg_rdata)
    );

    assign dout = mem_rdata;

    // R5: back-to-back reads never leave the block
    p_block_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_rd && $past(mem_rd)) |-> (mem_addr[AW-1:OW] == $past(mem_addr[AW-1:OW])));
endmodule

// File: tb/burst_read_seq_tb_top.sv
`timescale 1ns/1ps
module burst_read_seq_tb_top;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int BLK = 64;
    localparam int OW = 6;
    localparam int NFIX = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic          start_fixed = 1'b0;
    logic          we_n = 1'b1;
    logic          cfg_wr = 1'b0;
    logic [2:0]    cfg_lat = '0;
    logic          reg_avd = 1'b0;
    logic          reg_addr = 1'b0;
    logic [7:0]    reg_rdata;
    logic          mem_rd;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata = '0;
    logic [DW-1:0] dout;
    logic          dout_valid, rdy, irq;

    int  vectors = 0;
    int  miscompares = 0;
    int  cyc = 0;
    bit  finished = 1'b0;
    bit  err_exp = 1'b0;

    always #2.5 clk = ~clk;

    burst_read_seq #(.AW(AW), .DW(DW), .BLOCK_WORDS(BLK), .FIXED_LEN(NFIX)) dut_i (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .start_fixed(start_fixed), .we_n(we_n), .cfg_wr(cfg_wr), .cfg_lat(cfg_lat),
        .reg_avd(reg_avd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .dout(dout), .dout_valid(dout_valid), .rdy(rdy), .irq(irq)
    );

    function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
        logic [AW-1:0] m;
        m = a * 16'h9E37;
        return m ^ 16'h5A5A;
    endfunction

    function automatic logic [AW-1:0] word_addr(input logic [AW-1:0] base, input int k);
        logic [OW-1:0] off;
        off = base[OW-1:0] + OW'(k);
        return {base[AW-1:OW], off};
    endfunction

    // synchronous RAM model, one cycle read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= mem_word(mem_addr);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 20000 && !finished) begin
            finished = 1'b1;
            miscompares = miscompares + 1;
            $display("FAIL watchdog: act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors = vectors + 1;
        if (act !== exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [2:0] v);
        cfg_wr = 1'b1; cfg_lat = v;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic sel, input string req, input logic [7:0] exp);
        reg_avd = 1'b1; reg_addr = sel;
        @(negedge clk);
        reg_avd = 1'b0;
        chk(req, {24'b0, reg_rdata}, {24'b0, exp});
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        err_exp = 1'b0;
    endtask

    task automatic burst(input logic [AW-1:0] a, input bit fx, input int lat,
                         input int ncont, input int abort_at);
        int  total;
        bit  aborted;
        logic [2:0] other;
        aborted = 1'b0;
        cfg_write(3'(lat));
        reg_read(1'b0, "R2 latency write", 8'(lat));
        start = 1'b1; start_addr = a; start_fixed = fx;
        @(negedge clk);
        start = 1'b0;
        chk("R7 start clears irq", {31'b0, irq}, 32'd0);
        chk("R3 idle before first", {31'b0, dout_valid}, 32'd0);
        total = fx ? lat + NFIX + 2 : ncont;
        for (int j = 1; j <= total; j++) begin
            bit exp_dv, exp_irq;
            int k;
            @(negedge clk);
            if (abort_at > 0 && j > abort_at) aborted = 1'b1;
            k = (j == 1) ? 0 : j - lat;
            exp_dv = !aborted && ((j == 1) || (j >= lat + 1 && (!fx || j <= lat + NFIX - 1)));
            exp_irq = fx && (j >= lat + NFIX - 1);
            chk(aborted ? "R9 no word after abort" : "R3 valid timing",
                {31'b0, dout_valid}, {31'b0, exp_dv});
            chk(aborted ? "R9 no rdy after abort" : "R4 rdy pulse",
                {31'b0, rdy}, {31'b0, (j == 1) && !aborted});
            if (exp_dv && dout_valid)
                chk(j == 1 ? "R1 first word" : "R5 word address",
                    {16'b0, dout}, {16'b0, mem_word(word_addr(a, k))});
            chk(fx ? "R7 irq" : "R8 irq stays low", {31'b0, irq}, {31'b0, exp_irq});
            if (j == 9)
                chk("R10 latency readback in burst", {24'b0, reg_rdata}, {24'b0, 8'(lat)});
            we_n = 1'b1; cfg_wr = 1'b0; reg_avd = 1'b0; start = 1'b0;
            if (j == abort_at) begin we_n = 1'b0; err_exp = 1'b1; end
            if (!fx && j == 5) begin start = 1'b1; start_addr = ~a; start_fixed = 1'b1; end
            if (j == 7) begin
                other = (lat == 7) ? 3'd3 : 3'd7;
                cfg_wr = 1'b1; cfg_lat = other;
            end
            if (j == 8) begin reg_avd = 1'b1; reg_addr = 1'b0; end
        end
        we_n = 1'b1; cfg_wr = 1'b0; reg_avd = 1'b0; start = 1'b0;
        reg_read(1'b1, fx ? "R7 status done" : "R9 status", {6'b0, err_exp, fx && !aborted});
        if (!fx && !aborted) begin
            do_reset();
            chk("R6 reset stops stream", {31'b0, dout_valid}, 32'd0);
            reg_read(1'b0, "R11 latency after reset", 8'd4);
        end
    endtask

    initial begin
        int r;
        r = $urandom(32'd20240611);
        @(negedge clk);
        do_reset();
        chk("R11 dout_valid reset", {31'b0, dout_valid}, 32'd0);
        chk("R11 rdy reset", {31'b0, rdy}, 32'd0);
        chk("R11 irq reset", {31'b0, irq}, 32'd0);
        reg_read(1'b0, "R11 latency default", 8'd4);
        reg_read(1'b1, "R11 status clear", 8'd0);
        cfg_write(3'd2);
        reg_read(1'b0, "R2 illegal value ignored", 8'd4);
        cfg_write(3'd0);
        reg_read(1'b0, "R2 zero ignored", 8'd4);

        burst(16'h003E, 1'b1, 3, 0, 0);
        burst(16'h12F0, 1'b0, 7, 150, 0);
        burst(16'h7FFF, 1'b1, 7, 0, 0);
        burst(16'h0421, 1'b0, 4, 60, 30);
        burst(16'h0A00, 1'b1, 5, 0, 0);
        do_reset();
        reg_read(1'b1, "R11 error cleared by reset", 8'd0);

        for (int i = 0; i < 24; i++) begin
            logic [AW-1:0] a;
            bit fx;
            int lat, n;
            a   = AW'($urandom);
            fx  = 1'($urandom % 2);
            lat = 3 + int'($urandom % 5);
            n   = 20 + int'($urandom % 150);
            burst(a, fx, lat, n, 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule